// File: doc/BRIEF.md
# Latching Timestamp Counter

This peripheral keeps time in nanoseconds for software on a small 32-bit register bus. A free-running 64-bit counter advances by a fixed number of nanoseconds on every clock. A 64-bit offset register is added to the counter to give the current time. At reset the offset holds a start-up epoch, given in seconds and converted to nanoseconds.

Software takes a reading by writing a small value to the command register. The block then copies the corrected time into a 64-bit holding register, and can divide it by 1000 up to three times so the reading is in microseconds, milliseconds or seconds. Software then reads the holding register as two 32-bit halves. To set the time, software writes both halves of the holding register and then writes a command value of 4 or more. This rebases the offset so that the current time equals the value written.

The divisions run on a shared sequential divider that finds one quotient bit per clock. While it runs, the bus ready signal stays low and a pending access waits.

Top module: `ts_counter`

## Requirements
- R1: The register index is the 12-bit window address shifted right by two, so address bits 1:0 are ignored. Index 0 is the identity register, index 1 the command register, index 2 the low half (bits 31:0) of the holding register and index 3 its high half (bits 63:32).
- R2: A read of index 0 returns the parameter ID_VALUE.
- R3: A write to index 2 or 3 replaces only that 32-bit half of the holding register and keeps the other half. A read of index 2 or 3 returns that half.
- R4: The counter is zero during reset and adds NS_PER_CLK on every clock after reset. The offset resets to EPOCH_S times 10^9. A command write of 0 loads the holding register with counter plus offset, using the counter value at the clock edge that accepts the access.
- R5: A command write of 1, 2 or 3 loads counter plus offset and then divides it by 1000 that many times, as an unsigned division that truncates.
- R6: A command write of any 32-bit value 4 or above sets the offset to the holding register minus the counter and leaves the holding register unchanged. Later readings therefore count up from the value that was written.
- R7: All 64-bit additions and subtractions on the counter, the offset and the holding register wrap modulo 2^64.
- R8: An access to an undefined slot returns ready together with err high for one cycle and rdata of zero, and changes no state. The undefined slots are a read of index 1, a write of index 0, and any access to index 4 or above.
- R9: The bus raises ready for exactly one cycle per accepted request. For a plain access, ready comes in the cycle after the accepting edge. For a command write of n in 1..3, ready comes 64·n cycles later than for a plain access, and it stays low while the divider is busy. A request held high during that time is served afterwards and is not lost.
- R10: During and right after reset, ready, err and rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | WIN_W (12) | Byte address inside the 4 KiB window |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid while ready is high |
| ready | output | 1 | One-cycle completion strobe |
| err | output | 1 | Undefined-slot access, high together with ready |

## Verification
The bench records, in its own cycle counter, the exact edge that accepts each command. It then predicts the reading from that edge. A counter that is off by one edge, or a reading taken before the carry, shows up as a wrong low half. Divisions are checked at all three scale settings, and so is the exact ready latency. A divider that runs one bit too few or too many, or that does not clear its remainder between passes, gives a wrong quotient or a latency off by one. A rebase near the top of the 64-bit range and a reading after the wrap catch a subtraction done in the wrong order or at the wrong width. Writes to read-only and undefined slots are followed by read-backs of the holding register, so an access that should be ignored but corrupts state is seen.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int IDX_ID     = 0;
  localparam int IDX_CMD    = 1;
  localparam int IDX_LO     = 2;
  localparam int IDX_HI     = 3;
  localparam int NUM_SCALES = 4;
  localparam int SCALE_W    = $clog2(NUM_SCALES);
  localparam int DIVISOR    = 1000;
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;
endpackage

// File: rtl/ts_free_counter.sv
module ts_free_counter #(
  parameter int W    = 64,
  parameter int STEP = 10
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + W'(STEP);
  end
endmodule

// File: rtl/ts_div1000.sv
module ts_div1000 #(
  parameter int W       = 64,
  parameter int DIVISOR = 1000,
  parameter int STEP_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [W-1:0]      din,
  input  logic [STEP_W-1:0] steps,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      q
);
  localparam int REM_W = $clog2(DIVISOR);
  localparam int BIT_W = $clog2(W);
  localparam logic [REM_W:0] DIV_V = (REM_W+1)'(DIVISOR);

  logic [W-1:0]      dvd_q, dvd_n;
  logic [REM_W-1:0]  rem_q, rem_n;
  logic [REM_W:0]    trial;
  logic              ge;
  logic [BIT_W-1:0]  bit_q;
  logic [STEP_W-1:0] left_q;
  logic              last_bit;

  // one restoring quotient bit per cycle
  always_comb begin
    trial = {rem_q, dvd_q[W-1]};
    ge    = trial >= DIV_V;
    rem_n = ge ? REM_W'(trial - DIV_V) : trial[REM_W-1:0];
    dvd_n = {dvd_q[W-2:0], ge};
  end

  assign last_bit = bit_q == BIT_W'(W-1);
  assign done     = busy && last_bit && (left_q == STEP_W'(1));
  assign q        = dvd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      dvd_q  <= '0;
      rem_q  <= '0;
      bit_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      dvd_q  <= din;
      rem_q  <= '0;
      bit_q  <= '0;
      left_q <= steps;
    end else if (busy) begin
      dvd_q <= dvd_n;
      if (last_bit) begin
        bit_q  <= '0;
        rem_q  <= '0;
        left_q <= left_q - STEP_W'(1);
        if (left_q == STEP_W'(1)) busy <= 1'b0;
      end else begin
        bit_q <= bit_q + BIT_W'(1);
        rem_q <= rem_n;
      end
    end
  end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter logic [31:0] ID_VALUE   = 32'hC10C_0001,
  parameter int          NS_PER_CLK = 10,
  parameter logic [63:0] EPOCH_S    = 64'd1_700_000_000,
  parameter int          WIN_W      = 12,
  parameter int          DW         = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [WIN_W-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          err
);
  import ts_pkg::*;

  localparam int TW = 2 * DW;
  localparam logic [TW-1:0] EPOCH_NS = TW'(EPOCH_S * NS_PER_S);

  logic [TW-1:0] cnt_q, offset_q, data_q, now_time, div_q;
  logic [WIN_W-1:0] idx_w;
  logic is_id, is_cmd, is_lo, is_hi, bad, accept;
  logic scale_cmd, set_cmd, div_start, div_busy, div_done;

  ts_free_counter #(.W(TW), .STEP(NS_PER_CLK)) u_cnt (
    .clk(clk), .rst(rst), .count(cnt_q)
  );

  ts_div1000 #(.W(TW), .DIVISOR(DIVISOR), .STEP_W(SCALE_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .din(now_time),
    .steps(wdata[SCALE_W-1:0]), .busy(div_busy), .done(div_done), .q(div_q)
  );

  always_comb begin
    idx_w     = addr >> 2;
    is_id     = idx_w == WIN_W'(IDX_ID);
    is_cmd    = idx_w == WIN_W'(IDX_CMD);
    is_lo     = idx_w == WIN_W'(IDX_LO);
    is_hi     = idx_w == WIN_W'(IDX_HI);
    bad       = !(is_id || is_cmd || is_lo || is_hi) || (is_id && we) || (is_cmd && !we);
    accept    = req && !ready && !div_busy;
    scale_cmd = we && is_cmd && (wdata < DW'(NUM_SCALES));
    set_cmd   = we && is_cmd && !scale_cmd;
    now_time  = cnt_q + offset_q;
    div_start = accept && scale_cmd && (wdata[SCALE_W-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= EPOCH_NS;
      data_q   <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      ready <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
      if (div_done) begin
        data_q <= div_q;
        ready  <= 1'b1;
      end else if (accept) begin
        if (bad) begin
          err   <= 1'b1;
          ready <= 1'b1;
        end else if (set_cmd) begin
          offset_q <= data_q - cnt_q;
          ready    <= 1'b1;
        end else if (scale_cmd) begin
          data_q <= now_time;
          ready  <= !div_start;
        end else if (is_id) begin
          rdata <= ID_VALUE;
          ready <= 1'b1;
        end else if (is_lo) begin
          if (we) data_q[DW-1:0] <= wdata;
          else    rdata <= data_q[DW-1:0];
          ready <= 1'b1;
        end else begin
          if (we) data_q[TW-1:DW] <= wdata;
          else    rdata <= data_q[TW-1:DW];
          ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ts_counter_chk.sv
module ts_counter_chk #(
  parameter int NS = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          err,
  input logic [DW-1:0] rdata,
  input logic [63:0]   cnt,
  input logic          div_busy
);
  a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  a_r9_no_ready_while_dividing: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !ready);
  a_r8_err_with_ready: assert property (@(posedge clk) disable iff (rst)
    err |-> ready);
  a_r8_err_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == '0));
  a_r4_counter_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + 64'(NS)));
endmodule

bind ts_counter ts_counter_chk #(.NS(NS_PER_CLK), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .err(err), .rdata(rdata),
  .cnt(cnt_q), .div_busy(div_busy)
);

// File: tb/ts_counter_test.sv
module ts_counter_test;
  localparam logic [31:0] ID_V  = 32'hC10C_0001;
  localparam int          NS    = 10;
  localparam logic [63:0] EP_S  = 64'd1_700_000_000;
  localparam logic [63:0] EP_NS = EP_S * 64'd1_000_000_000;

  logic clk = 0, rst = 1, req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ready, err;
  longint unsigned cyc;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ts_counter uut (.clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready), .err(err));

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        e;
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{1'b1, 12'h008, 32'h89AB_CDEF, 32'h0,         1'b0},
    '{1'b1, 12'h00C, 32'h0123_4567, 32'h0,         1'b0},
    '{1'b0, 12'h008, 32'h0,         32'h89AB_CDEF, 1'b0},
    '{1'b0, 12'h00C, 32'h0,         32'h0123_4567, 1'b0},
    '{1'b0, 12'h000, 32'h0,         ID_V,          1'b0},
    '{1'b0, 12'h004, 32'h0,         32'h0,         1'b1},
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,         1'b1},
    '{1'b1, 12'h010, 32'hDEAD_BEEF, 32'h0,         1'b1},
    '{1'b0, 12'hFFC, 32'h0,         32'h0,         1'b1},
    '{1'b0, 12'h00E, 32'h0,         32'h0123_4567, 1'b0},
    '{1'b0, 12'h009, 32'h0,         32'h89AB_CDEF, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic e, output int lat,
                        output longint unsigned c);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; c = cyc; lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (ready) break;
    end
    rd = rdata; e = err;
    req = 0; we = 0;
  endtask

  task automatic read64(output logic [63:0] v);
    logic [31:0] lo, hi; logic e; int l; longint unsigned c;
    access(1'b0, 12'h008, 32'h0, lo, e, l, c);
    access(1'b0, 12'h00C, 32'h0, hi, e, l, c);
    v = {hi, lo};
  endtask

  task automatic write64(input logic [63:0] v);
    logic [31:0] rd; logic e; int l; longint unsigned c;
    access(1'b1, 12'h008, v[31:0], rd, e, l, c);
    access(1'b1, 12'h00C, v[63:32], rd, e, l, c);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic e; int lat; longint unsigned c, c1, c2;
    logic [63:0] v, exp, t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 ready in reset", 64'(ready), 64'd0);
    check("R10 err in reset", 64'(err), 64'd0);
    rst = 0;
    @(negedge clk);
    check("R10 rdata after reset", 64'(rdata), 64'd0);
    check("R10 ready idle", 64'(ready), 64'd0);

    // table walk: R1 R2 R3 R8
    for (int i = 0; i <= 10; i++) begin
      access(VEC[i].w, VEC[i].a, VEC[i].d, rd, e, lat, c);
      check($sformatf("R8 err vec%0d", i), 64'(e), 64'(VEC[i].e));
      if (!VEC[i].w) check($sformatf("R1 R2 R3 rdata vec%0d", i), 64'(rd), 64'(VEC[i].exp));
      check($sformatf("R9 plain latency vec%0d", i), 64'(lat), 64'd1);
    end
    read64(v);
    check("R8 ignored writes kept data", v, 64'h0123_4567_89AB_CDEF);

    // R4 plain latch
    access(1'b1, 12'h004, 32'd0, rd, e, lat, c);
    check("R9 latch0 latency", 64'(lat), 64'd1);
    read64(v);
    check("R4 latch ns", v, EP_NS + c * NS);

    // R5 scaled latches with exact latency
    for (int n = 1; n <= 3; n++) begin
      access(1'b1, 12'h004, 32'(n), rd, e, lat, c);
      check($sformatf("R9 latency scale%0d", n), 64'(lat), 64'(64 * n + 1));
      exp = EP_NS + c * NS;
      for (int k = 0; k < n; k++) exp = exp / 64'd1000;
      read64(v);
      check($sformatf("R5 scale%0d", n), v, exp);
    end

    // R6 set time
    t = 64'd5_000_000_000_000;
    write64(t);
    access(1'b1, 12'h004, 32'd7, rd, e, lat, c1);
    read64(v);
    check("R6 set keeps data", v, t);
    repeat (13) @(negedge clk);
    access(1'b1, 12'h004, 32'd0, rd, e, lat, c2);
    read64(v);
    check("R6 time after set", v, t + (c2 - c1) * NS);
    access(1'b1, 12'h004, 32'd2, rd, e, lat, c2);
    read64(v);
    check("R6 R5 ms after set", v, (t + (c2 - c1) * NS) / 64'd1_000_000);

    // R7 wrap
    t = 64'hFFFF_FFFF_FFFF_FFF0;
    write64(t);
    access(1'b1, 12'h004, 32'hFFFF_FFFF, rd, e, lat, c1);
    repeat (5) @(negedge clk);
    access(1'b1, 12'h004, 32'd0, rd, e, lat, c2);
    read64(v);
    exp = t + (c2 - c1) * NS;
    check("R7 wrapped time", v, exp);
    check("R7 wrapped past zero", 64'(v < 64'h1000), 64'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule